// File: doc/BRIEF.md
# Dual-Width External Memory Interface

This block turns single accesses from an internal memory bus into pin-level cycles for external static RAM and flash. Two regions are served, a code region and a data region, and each one has its own active-low chip select. A strap input for each region says whether the region is 8 bits wide or 16 bits wide, where the 16-bit form is built from a pair of byte-wide devices. One shared pin changes its role from one access to the next according to that setting. In a byte-wide region it carries the least significant byte-address bit. In a 16-bit region it is the write strobe for the upper byte lane.

The internal side uses a request/ready handshake. A request carries a 20-bit byte address, a byte or halfword size, a direction and write data. Address bits [19:18] select the space: `00` is the data region, `1x` is the code region, and `01` is a window in data space that reaches the code region. Every external cycle has three phases. Chip select is driven alone for one setup cycle. The strobe then runs for one cycle plus a per-region wait-state count, which is a parameter. A hold cycle with chip select still asserted ends the cycle. A halfword to a byte-wide region becomes two such cycles, and the two bytes are merged before ready is returned.

Top module: `ext_mem_if`

## Requirements
- R1: A request whose address bits [19:18] are `1x` or `01` asserts only `cs_code_n`. A request with `00` asserts only `cs_data_n`. Both chip selects are never low together, and both are high while idle.
- R2: In a byte-wide region, `mem_a0_whn` carries the byte-address bit 0 of the current byte cycle for the whole time chip select is low. Writes pulse only `mem_wel_n`, and reads pulse only `mem_oe_n`.
- R3: In a 16-bit region, `mem_a0_whn` is the upper-lane write strobe and stays high outside write strobes. A byte write to an even address pulses only `mem_wel_n`. A byte write to an odd address pulses only `mem_a0_whn`. A halfword write pulses both.
- R4: While a chip select is low, `mem_wa` equals byte-address bits [17:1] of the request.
- R5: A halfword (`req_half`=1) to a byte-wide region runs two byte cycles, the even address first and then the odd one. Chip select stays low between the two cycles. The result is returned as {odd byte, even byte} with a single ready pulse.
- R6: Chip select goes low one cycle before the read or write strobe falls, and it rises one cycle after the strobe rises.
- R7: The strobe phase lasts 1+`CODE_WS` cycles in the code region and 1+`DATA_WS` cycles in the data region. Each count lies in 0..7.
- R8: `rdy` is high for exactly one cycle, during the final hold cycle. `rdata` is valid from that cycle on. Byte reads are zero-extended. A byte read from an odd address of a 16-bit region takes the upper lane `mem_d_i[15:8]`.
- R9: `mem_d_oe` is high only during write cycles and never while `mem_oe_n` is low. Write data is driven as follows:
  - A byte-wide region drives the byte on `mem_d_o[7:0]` with the upper lane zero.
  - A 16-bit region drives the halfword as is, or replicates a single byte onto both lanes.
- R10: A request is accepted only from idle. After each ready pulse there is at least one idle cycle with both chip selects high, and a request held through that cycle begins a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cfg_code_wide | input | 1 | Code region is 16 bits wide (1) or 8 bits wide (0) |
| cfg_data_wide | input | 1 | Data region is 16 bits wide (1) or 8 bits wide (0) |
| req | input | 1 | Access request, held until `rdy` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_half | input | 1 | 1 = halfword, 0 = byte |
| req_addr | input | 20 | Byte address; bits [19:18] select the space |
| req_wdata | input | 16 | Write data; a byte uses [7:0] |
| rdy | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result |
| mem_wa | output | 17 | External word address (byte-address bits 17:1) |
| mem_a0_whn | output | 1 | Multifunction pin: address bit 0 or upper write strobe (active low) |
| mem_d_o | output | 16 | Data driven to the external bus |
| mem_d_oe | output | 1 | Drive enable for `mem_d_o` |
| mem_d_i | input | 16 | Data read from the external bus |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_wel_n | output | 1 | Lower (or only) write strobe, active low |
| cs_code_n | output | 1 | Code region chip select, active low |
| cs_data_n | output | 1 | Data region chip select, active low |

## Verification
The bench builds the block with `CODE_WS`=2 and `DATA_WS`=0. With these values, the zero-wait strobe of the data region and a stretched three-cycle strobe in the code region both occur within one run, and the strobe length is measured against each. The bench flips both width straps during the run, so the 8-bit and 16-bit behaviour of the multifunction pin, and the split halfword, are checked in both regions. The bench also reaches the code region through the overlay window. Data written in one width is read back in the other, which ties the byte-lane placement of the two modes together.

// File: rtl/ext_mem_pkg.sv
package ext_mem_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_STRB  = 2'd2,
      ST_HOLD  = 2'd3
   } xfer_st_e;

   typedef struct packed {
      logic code;
      logic wide;
      logic we;
      logic half;
   } xfer_attr_t;

endpackage

// File: rtl/ext_mem_decode.sv
module ext_mem_decode #(
   parameter bit OVERLAY_EN = 1'b1
) (
   input  logic [1:0] space_sel,
   input  logic       cfg_code_wide,
   input  logic       cfg_data_wide,
   output logic       is_code,
   output logic       is_wide
);

   generate
      if (OVERLAY_EN) begin : g_overlay
         // window 01 in data space maps onto the code devices
         assign is_code = space_sel[1] | space_sel[0];
      end else begin : g_plain
         assign is_code = space_sel[1];
      end
   endgenerate

   assign is_wide = is_code ? cfg_code_wide : cfg_data_wide;

endmodule

// File: rtl/ext_mem_seq.sv
module ext_mem_seq
   import ext_mem_pkg::*;
#(
   parameter int WS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            split,
   input  logic [WS_W-1:0] ws,
   output xfer_st_e        st,
   output logic            phase,
   output logic            cap,
   output logic            done
);

   logic [WS_W-1:0] wcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         phase <= 1'b0;
         wcnt  <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  st    <= ST_SETUP;
                  phase <= 1'b0;
               end
            end
            ST_SETUP: begin
               st   <= ST_STRB;
               wcnt <= ws;
            end
            ST_STRB: begin
               if (wcnt == '0) st <= ST_HOLD;
               else            wcnt <= wcnt - 1'b1;
            end
            ST_HOLD: begin
               if (split && !phase) begin
                  phase <= 1'b1;
                  st    <= ST_SETUP;
               end else begin
                  st <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign cap  = (st == ST_STRB) && (wcnt == '0);
   assign done = (st == ST_HOLD) && (!split || phase);

endmodule

// File: rtl/ext_mem_pins.sv
module ext_mem_pins
   import ext_mem_pkg::*;
#(
   parameter int BA_W = 18,
   parameter int DW   = 16
) (
   input  xfer_st_e        st,
   input  logic            phase,
   input  xfer_attr_t      attr,
   input  logic [BA_W-1:0] ba,
   input  logic [DW-1:0]   wdata,
   output logic [BA_W-2:0] mem_wa,
   output logic            mem_a0_whn,
   output logic [DW-1:0]   mem_d_o,
   output logic            mem_d_oe,
   output logic            mem_oe_n,
   output logic            mem_wel_n,
   output logic            cs_code_n,
   output logic            cs_data_n
);

   localparam int LANE = DW / 2;

   logic active, strb, lane_a0, wr_lo, wr_hi;
   logic [LANE-1:0] narrow_byte;

   assign active  = (st != ST_IDLE);
   assign strb    = (st == ST_STRB);
   assign lane_a0 = attr.half ? phase : ba[0];

   assign cs_code_n = !(active && attr.code);
   assign cs_data_n = !(active && !attr.code);
   assign mem_wa    = ba[BA_W-1:1];

   assign mem_oe_n = !(strb && !attr.we);
   assign wr_lo    = strb && attr.we && (!attr.wide || attr.half || !ba[0]);
   assign wr_hi    = strb && attr.we && attr.wide && (attr.half || ba[0]);
   assign mem_wel_n = !wr_lo;

   always_comb begin
      if (!active)        mem_a0_whn = 1'b1;
      else if (attr.wide) mem_a0_whn = !wr_hi;
      else                mem_a0_whn = lane_a0;
   end

   assign mem_d_oe    = active && attr.we;
   assign narrow_byte = (attr.half && phase) ? wdata[DW-1:LANE] : wdata[LANE-1:0];

   generate
      for (genvar g = 0; g < 2; g++) begin : g_lane
         always_comb begin
            if (attr.wide)
               mem_d_o[g*LANE +: LANE] = attr.half ? wdata[g*LANE +: LANE] : wdata[LANE-1:0];
            else
               mem_d_o[g*LANE +: LANE] = (g == 0) ? narrow_byte : '0;
         end
      end
   endgenerate

endmodule

// File: rtl/ext_mem_rdasm.sv
module ext_mem_rdasm #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap,
   input  logic          phase,
   input  logic          we,
   input  logic          wide,
   input  logic          half,
   input  logic          a0,
   input  logic [DW-1:0] mem_d_i,
   output logic [DW-1:0] rdata
);

   localparam int LANE = DW / 2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (cap && !we) begin
         if (wide) begin
            if (half)    rdata <= mem_d_i;
            else if (a0) rdata <= {{LANE{1'b0}}, mem_d_i[DW-1:LANE]};
            else         rdata <= {{LANE{1'b0}}, mem_d_i[LANE-1:0]};
         end else if (!phase) begin
            rdata <= {{LANE{1'b0}}, mem_d_i[LANE-1:0]};
         end else begin
            rdata[DW-1:LANE] <= mem_d_i[LANE-1:0];
         end
      end
   end

endmodule

// File: rtl/ext_mem_if.sv
module ext_mem_if
   import ext_mem_pkg::*;
#(
   parameter int BA_W       = 18,
   parameter int CODE_WS    = 3,
   parameter int DATA_WS    = 1,
   parameter int WS_MAX     = 7,
   parameter bit OVERLAY_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_code_wide,
   input  logic                 cfg_data_wide,
   input  logic                 req,
   input  logic                 req_we,
   input  logic                 req_half,
   input  logic [BA_W+1:0]      req_addr,
   input  logic [15:0]          req_wdata,
   output logic                 rdy,
   output logic [15:0]          rdata,
   output logic [BA_W-2:0]      mem_wa,
   output logic                 mem_a0_whn,
   output logic [15:0]          mem_d_o,
   output logic                 mem_d_oe,
   input  logic [15:0]          mem_d_i,
   output logic                 mem_oe_n,
   output logic                 mem_wel_n,
   output logic                 cs_code_n,
   output logic                 cs_data_n
);

   localparam int IA_W = BA_W + 2;
   localparam int DW   = 16;
   localparam int WS_W = $clog2(WS_MAX + 1);

   generate
      if (CODE_WS < 0 || CODE_WS > WS_MAX) begin : g_bad_cws
         $error("CODE_WS out of range");
      end
      if (DATA_WS < 0 || DATA_WS > WS_MAX) begin : g_bad_dws
         $error("DATA_WS out of range");
      end
      if (BA_W < 2) begin : g_bad_baw
         $error("BA_W too small");
      end
   endgenerate

   xfer_st_e        st;
   xfer_attr_t      attr_q;
   logic [BA_W-1:0] ba_q;
   logic [DW-1:0]   wd_q;
   logic            dec_code, dec_wide, start, phase, cap, done, split;
   logic [WS_W-1:0] ws_sel;

   ext_mem_decode #(.OVERLAY_EN(OVERLAY_EN)) decode_i (
      .space_sel     (req_addr[IA_W-1:IA_W-2]),
      .cfg_code_wide (cfg_code_wide),
      .cfg_data_wide (cfg_data_wide),
      .is_code       (dec_code),
      .is_wide       (dec_wide)
   );

   assign start = req && (st == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         attr_q <= '0;
         ba_q   <= '0;
         wd_q   <= '0;
      end else if (start) begin
         attr_q <= '{code: dec_code, wide: dec_wide, we: req_we, half: req_half};
         ba_q   <= req_addr[BA_W-1:0];
         wd_q   <= req_wdata;
      end
   end

   assign split  = attr_q.half && !attr_q.wide;
   assign ws_sel = attr_q.code ? WS_W'(CODE_WS) : WS_W'(DATA_WS);

   ext_mem_seq #(.WS_W(WS_W)) seq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .split (split),
      .ws    (ws_sel),
      .st    (st),
      .phase (phase),
      .cap   (cap),
      .done  (done)
   );

   ext_mem_pins #(.BA_W(BA_W), .DW(DW)) pins_i (
      .st         (st),
      .phase      (phase),
      .attr       (attr_q),
      .ba         (ba_q),
      .wdata      (wd_q),
      .mem_wa     (mem_wa),
      .mem_a0_whn (mem_a0_whn),
      .mem_d_o    (mem_d_o),
      .mem_d_oe   (mem_d_oe),
      .mem_oe_n   (mem_oe_n),
      .mem_wel_n  (mem_wel_n),
      .cs_code_n  (cs_code_n),
      .cs_data_n  (cs_data_n)
   );

   ext_mem_rdasm #(.DW(DW)) rdasm_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap     (cap),
      .phase   (phase),
      .we      (attr_q.we),
      .wide    (attr_q.wide),
      .half    (attr_q.half),
      .a0      (ba_q[0]),
      .mem_d_i (mem_d_i),
      .rdata   (rdata)
   );

   assign rdy = done;

endmodule

// File: rtl/ext_mem_if_chk.sv
module ext_mem_if_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_code_wide,
   input logic cfg_data_wide,
   input logic rdy,
   input logic mem_a0_whn,
   input logic mem_d_oe,
   input logic mem_oe_n,
   input logic mem_wel_n,
   input logic cs_code_n,
   input logic cs_data_n
);

   logic cs_any;
   assign cs_any = !(cs_code_n && cs_data_n);

   assert_cs_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(!cs_code_n && !cs_data_n));

   assert_strobe_in_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n || !mem_wel_n) |-> cs_any);

   assert_oe_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_oe_n) |-> $past(cs_any));

   assert_wel_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_wel_n) |-> $past(cs_any));

   assert_oe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> cs_any);

   assert_wel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wel_n) |-> cs_any);

   assert_no_hi_wr_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((!cs_code_n && cfg_code_wide) || (!cs_data_n && cfg_data_wide)) && !mem_oe_n
      |-> mem_a0_whn);

   assert_no_drive_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_d_oe |-> mem_oe_n);

   assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rdy |=> !rdy);

   assert_idle_after_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rdy |=> (cs_code_n && cs_data_n));

endmodule

bind ext_mem_if ext_mem_if_chk chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_code_wide (cfg_code_wide),
   .cfg_data_wide (cfg_data_wide),
   .rdy           (rdy),
   .mem_a0_whn    (mem_a0_whn),
   .mem_d_oe      (mem_d_oe),
   .mem_oe_n      (mem_oe_n),
   .mem_wel_n     (mem_wel_n),
   .cs_code_n     (cs_code_n),
   .cs_data_n     (cs_data_n)
);

// File: tb/ext_mem_if_tb_top.sv
module ext_mem_if_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int CWS = 2;
   localparam int DWS = 0;

   typedef struct {
      logic        cc, cd, oe, wel, a0, rdy, doe;
      logic [15:0] dout;
      logic [16:0] wa;
   } vec_t;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cfg_code_wide = 1'b0, cfg_data_wide = 1'b0;
   logic        req = 1'b0, req_we = 1'b0, req_half = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        rdy, mem_a0_whn, mem_d_oe, mem_oe_n, mem_wel_n, cs_code_n, cs_data_n;
   logic [15:0] rdata, mem_d_o, mem_d_i;
   logic [16:0] mem_wa;

   logic [7:0] dev_code [0:1023];
   logic [7:0] dev_data [0:1023];
   logic [7:0] sh_code  [0:1023];
   logic [7:0] sh_data  [0:1023];

   vec_t exp_q[$];
   int   vecs = 0, miss = 0, cyc = 0;
   logic chk_on = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ext_mem_if #(.CODE_WS(CWS), .DATA_WS(DWS)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_code_wide(cfg_code_wide), .cfg_data_wide(cfg_data_wide),
      .req(req), .req_we(req_we), .req_half(req_half), .req_addr(req_addr),
      .req_wdata(req_wdata), .rdy(rdy), .rdata(rdata), .mem_wa(mem_wa),
      .mem_a0_whn(mem_a0_whn), .mem_d_o(mem_d_o), .mem_d_oe(mem_d_oe), .mem_d_i(mem_d_i),
      .mem_oe_n(mem_oe_n), .mem_wel_n(mem_wel_n), .cs_code_n(cs_code_n), .cs_data_n(cs_data_n)
   );

   // external device model: byte-addressed storage shared by both widths
   always_comb begin
      mem_d_i = 16'hEEEE;
      if (!cs_code_n && !mem_oe_n)
         mem_d_i = cfg_code_wide ? {dev_code[{mem_wa[8:0], 1'b1}], dev_code[{mem_wa[8:0], 1'b0}]}
                                 : {8'hEE, dev_code[{mem_wa[8:0], mem_a0_whn}]};
      else if (!cs_data_n && !mem_oe_n)
         mem_d_i = cfg_data_wide ? {dev_data[{mem_wa[8:0], 1'b1}], dev_data[{mem_wa[8:0], 1'b0}]}
                                 : {8'hEE, dev_data[{mem_wa[8:0], mem_a0_whn}]};
   end

   always @(negedge clk) begin
      if (!cs_code_n) begin
         if (cfg_code_wide) begin
            if (!mem_wel_n)  dev_code[{mem_wa[8:0], 1'b0}] = mem_d_o[7:0];
            if (!mem_a0_whn) dev_code[{mem_wa[8:0], 1'b1}] = mem_d_o[15:8];
         end else if (!mem_wel_n) dev_code[{mem_wa[8:0], mem_a0_whn}] = mem_d_o[7:0];
      end
      if (!cs_data_n) begin
         if (cfg_data_wide) begin
            if (!mem_wel_n)  dev_data[{mem_wa[8:0], 1'b0}] = mem_d_o[7:0];
            if (!mem_a0_whn) dev_data[{mem_wa[8:0], 1'b1}] = mem_d_o[15:8];
         end else if (!mem_wel_n) dev_data[{mem_wa[8:0], mem_a0_whn}] = mem_d_o[7:0];
      end
   end

   function automatic vec_t idle_v();
      vec_t v;
      v.cc = 1; v.cd = 1; v.oe = 1; v.wel = 1; v.a0 = 1; v.rdy = 0; v.doe = 0;
      v.dout = '0; v.wa = '0;
      return v;
   endfunction

   task automatic cmp(input string rq, input string nm, input logic [31:0] got, input logic [31:0] exp);
      if (got !== exp) begin
         miss++;
         $display("FAIL %s %s at cycle %0d: got %h expected %h", rq, nm, cyc, got, exp);
      end
   endtask

   // cycle-by-cycle comparison against the expected pin queue
   always @(negedge clk) begin
      vec_t v;
      cyc++;
      if (chk_on) begin
         v = (exp_q.size() > 0) ? exp_q.pop_front() : idle_v();
         vecs++;
         cmp("R1/R6", "cs_code_n", 32'(cs_code_n), 32'(v.cc));
         cmp("R1/R6", "cs_data_n", 32'(cs_data_n), 32'(v.cd));
         cmp("R2/R7", "mem_oe_n", 32'(mem_oe_n), 32'(v.oe));
         cmp("R2/R3/R7", "mem_wel_n", 32'(mem_wel_n), 32'(v.wel));
         cmp("R2/R3", "mem_a0_whn", 32'(mem_a0_whn), 32'(v.a0));
         cmp("R8/R5", "rdy", 32'(rdy), 32'(v.rdy));
         cmp("R9", "mem_d_oe", 32'(mem_d_oe), 32'(v.doe));
         if (!v.cc || !v.cd) cmp("R4", "mem_wa", 32'(mem_wa), 32'(v.wa));
         if (v.doe) cmp("R9", "mem_d_o", 32'(mem_d_o), 32'(v.dout));
      end
      if (cyc > 50000) begin
         miss++;
         $display("FAIL R10 watchdog: got no completion expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
         $finish;
      end
   end

   function automatic logic [7:0] shb(input logic c, input logic [9:0] i);
      return c ? sh_code[i] : sh_data[i];
   endfunction

   task automatic xfer(input logic [19:0] a, input logic we, input logic half,
                       input logic [15:0] d, input string rq);
      logic c, w, lb;
      int ws, nx, n;
      logic [15:0] expr;
      vec_t v;
      c  = a[19] | a[18];
      w  = c ? cfg_code_wide : cfg_data_wide;
      ws = c ? CWS : DWS;
      nx = (!w && half) ? 2 : 1;
      exp_q.push_back(idle_v());  // R10: request seen in idle, first vector still idle
      for (int ph = 0; ph < nx; ph++) begin
         lb = half ? ph[0] : a[0];
         v.cc = !c; v.cd = c; v.rdy = 0; v.doe = we; v.wa = a[17:1];
         if (w) v.dout = half ? d : {d[7:0], d[7:0]};
         else   v.dout = {8'h00, (half && ph == 1) ? d[15:8] : d[7:0]};
         v.oe = 1; v.wel = 1; v.a0 = w ? 1'b1 : lb;
         exp_q.push_back(v);
         for (int s = 0; s <= ws; s++) begin
            v.oe  = we;
            v.wel = !(we && (!w || half || !a[0]));
            v.a0  = (w && we && (half || a[0])) ? 1'b0 : (w ? 1'b1 : lb);
            exp_q.push_back(v);
         end
         v.oe = 1; v.wel = 1; v.a0 = w ? 1'b1 : lb; v.rdy = (ph == nx - 1);
         exp_q.push_back(v);
      end
      n = nx * (ws + 3);
      expr = half ? {shb(c, {a[9:1], 1'b1}), shb(c, {a[9:1], 1'b0})} : {8'h00, shb(c, a[9:0])};
      if (we) begin
         if (half) begin
            if (c) begin sh_code[{a[9:1],1'b0}] = d[7:0]; sh_code[{a[9:1],1'b1}] = d[15:8]; end
            else   begin sh_data[{a[9:1],1'b0}] = d[7:0]; sh_data[{a[9:1],1'b1}] = d[15:8]; end
         end else begin
            if (c) sh_code[a[9:0]] = d[7:0];
            else   sh_data[a[9:0]] = d[7:0];
         end
      end
      req = 1; req_we = we; req_half = half; req_addr = a; req_wdata = d;
      @(posedge clk); #1;
      repeat (n) @(posedge clk);
      #1;
      if (!we) begin
         vecs++;
         cmp(rq, "rdata", 32'(rdata), 32'(expr));
      end
      req = 0;
      @(posedge clk); #1;
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) begin
         dev_code[i] = 8'(i * 7 + 3);  sh_code[i] = 8'(i * 7 + 3);
         dev_data[i] = 8'(i * 13 + 90); sh_data[i] = 8'(i * 13 + 90);
      end
      @(posedge clk); #1;
      chk_on = 1;                        // reset state: idle pins (R1)
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(posedge clk); #1;

      // byte-wide data region (R2, R5, R9)
      cfg_data_wide = 0;
      xfer(20'h00005, 1, 0, 16'h00A7, "R2");
      xfer(20'h00005, 0, 0, 16'h0000, "R2");
      xfer(20'h00010, 1, 1, 16'hBEEF, "R5");
      xfer(20'h00010, 0, 1, 16'h0000, "R5");
      xfer(20'h00031, 0, 1, 16'h0000, "R5");

      // 16-bit data region (R3, R8, R9)
      cfg_data_wide = 1;
      xfer(20'h00020, 1, 0, 16'h0011, "R3");
      xfer(20'h00021, 1, 0, 16'h0022, "R3");
      xfer(20'h00022, 1, 1, 16'hC0DE, "R3");
      xfer(20'h00020, 0, 1, 16'h0000, "R3");
      xfer(20'h00021, 0, 0, 16'h0000, "R8");
      xfer(20'h00022, 0, 0, 16'h0000, "R8");
      xfer(20'h00010, 0, 1, 16'h0000, "R5");   // written narrow, read wide

      // code region, direct and via overlay window (R1, R4, R7)
      cfg_code_wide = 0;
      xfer(20'h80044, 0, 1, 16'h0000, "R7");
      xfer(20'hC0101, 1, 0, 16'h005C, "R1");
      xfer(20'h40101, 0, 0, 16'h0000, "R1");
      cfg_code_wide = 1;
      xfer(20'h40100, 0, 1, 16'h0000, "R1");
      xfer(20'h80203, 1, 0, 16'h0093, "R4");
      xfer(20'h80202, 0, 1, 16'h0000, "R4");
      xfer(20'h803FE, 1, 1, 16'h1234, "R7");
      xfer(20'h403FE, 0, 1, 16'h0000, "R10");

      repeat (4) @(posedge clk);
      #1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end

endmodule